// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block keeps the program counter of a single-cycle processor. It returns the instruction word stored at the current address, and on every clock edge it moves the counter on to the next address. The instruction store is a word-addressed array inside the block. It is filled through a synchronous preload port, usually while reset is held, and it is read combinationally at the current counter value.

Three candidates compete for the next address. The first is the sequential address, which is the counter plus four. The second is a PC-relative branch target, where a signed 16-bit word offset from the current instruction is shifted left by two and added to the sequential address. The third is a region jump, which keeps the top four bits of the sequential address and fills the rest from the 26-bit target field of the current instruction followed by two zero bits.

The decoder does not drive the address multiplexer select directly. It supplies a branch flag and a jump flag, and the datapath supplies its zero condition. The block combines these inputs into its own selection.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is loaded with 0 at that edge. The reset is synchronous.
- R2: When `jmp_flag` is low and the branch is not taken, the counter advances by 4 at each rising edge, and it always stays a multiple of 4.
- R3: When `br_flag` and `alu_zero` are both high and `jmp_flag` is low, the next counter value is PC + 4 + (sign-extended instruction bits [15:0] shifted left by 2). Negative offsets move backwards.
- R4: A branch is taken only when both `br_flag` and `alu_zero` are high. If either is high alone, the counter follows the sequential address.
- R5: When `jmp_flag` is high, the next counter value is {(PC+4)[31:28], instruction bits [25:0], 2'b00}.
- R6: When `jmp_flag` is high, the jump is taken whatever the values of `br_flag` and `alu_zero`.
- R7: `instr` equals the stored word whose index is PC bits [31:2]. It follows a counter change in the same cycle, with no register in the read path.
- R8: When PC bits [31:2] are at or above the memory depth, `instr` is all zeros. A jump made from such an all-zero word goes to the base of the current 256 MB region.
- R9: When `ld_we` is high at a rising edge, `ld_data` is written into word `ld_addr` of the store. This happens whether or not reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on the rising edge |
| rst | input | 1 | Synchronous reset of the counter |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | $clog2(DEPTH) | Preload word index |
| ld_data | input | 32 | Preload word value |
| br_flag | input | 1 | Conditional branch requested by the decoder |
| jmp_flag | input | 1 | Unconditional jump requested by the decoder |
| alu_zero | input | 1 | Zero condition from the execution datapath |
| instr | output | 32 | Instruction word at the current counter value |
| pc | output | 32 | Current counter value |

## Verification
The only state in the block is the counter, together with the stored words. A wrong next-address choice therefore shows on `pc` one edge after the cycle in which the choice was made. Because the read path is combinational, the same error shows on `instr` in that same cycle. A wrong offset scaling, a wrong sign extension or a wrong jump concatenation produces a counter value that differs from the value predicted from the visible instruction fields. Each directed step compares both outputs right after the edge, so any divergence is caught at its first cycle rather than after it has spread.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int XLEN       = 32;
    localparam int IMM_W      = 16;
    localparam int TGT_W      = 26;
    localparam int REGION_W   = 4;
    localparam int ALIGN_W    = 2;
    localparam logic [XLEN-1:0] STEP      = XLEN'(4);
    localparam logic [XLEN-1:0] RESET_PC  = '0;

    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_BRA  = 2'd1,
        NPC_JMP  = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } fetch_state_t;

    function automatic logic [XLEN-1:0] branch_offset(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W-ALIGN_W){imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ifu_branch_dec.sv
module ifu_branch_dec
    import ifu_pkg::*;
(
    input  logic     br_req,
    input  logic     jmp_req,
    input  logic     cond_zero,
    output npc_sel_e sel
);
    logic take_br;

    always_comb begin
        take_br = br_req & cond_zero;
        if (jmp_req) begin
            sel = NPC_JMP;
        end else if (take_br) begin
            sel = NPC_BRA;
        end else begin
            sel = NPC_SEQ;
        end
    end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
(
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_word,
    input  npc_sel_e        sel,
    output logic [XLEN-1:0] nxt_pc
);
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] bra_addr;
    logic [XLEN-1:0] jmp_addr;

    always_comb begin
        seq_addr = cur_pc + STEP;
        bra_addr = seq_addr + branch_offset(cur_word[IMM_W-1:0]);
        jmp_addr = {seq_addr[XLEN-1 -: REGION_W], cur_word[TGT_W-1:0], {ALIGN_W{1'b0}}};
        unique case (sel)
            NPC_BRA: nxt_pc = bra_addr;
            NPC_JMP: nxt_pc = jmp_addr;
            default: nxt_pc = seq_addr;
        endcase
    end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
    import ifu_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_word,
    input  logic [XLEN-1:0] rd_pc,
    output logic [XLEN-1:0] rd_word
);
    localparam int WIDX_W = XLEN - ALIGN_W;
    localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(DEPTH);

    logic [XLEN-1:0]   store_q [DEPTH];
    logic [WIDX_W-1:0] word_idx;
    logic              in_range;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx] <= wr_word;
        end
    end

    always_comb begin
        word_idx = rd_pc[XLEN-1:ALIGN_W];
        in_range = (word_idx < LIMIT);
        rd_word  = in_range ? store_q[word_idx[AW-1:0]] : '0;
    end
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic            br_flag,
    input  logic            jmp_flag,
    input  logic            alu_zero,
    output logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] pc
);
    fetch_state_t    st_d, st_q;
    npc_sel_e        sel;
    logic [XLEN-1:0] nxt;

    ifu_imem #(.DEPTH(DEPTH)) u_imem (
        .clk     (clk),
        .wr_en   (ld_we),
        .wr_idx  (ld_addr),
        .wr_word (ld_data),
        .rd_pc   (st_q.pc),
        .rd_word (instr)
    );

    ifu_branch_dec u_dec (
        .br_req    (br_flag),
        .jmp_req   (jmp_flag),
        .cond_zero (alu_zero),
        .sel       (sel)
    );

    ifu_next_pc u_npc (
        .cur_pc   (st_q.pc),
        .cur_word (instr),
        .sel      (sel),
        .nxt_pc   (nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = rst ? RESET_PC : nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk
    import ifu_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            br_flag,
    input logic            jmp_flag,
    input logic            alu_zero,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] boff;
    assign pc4  = pc + 32'd4;
    assign boff = {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1
    rst_pc_zero_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!jmp_flag && !(br_flag && alu_zero)) |=> pc == $past(pc4));

    // R2
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R3
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!jmp_flag && br_flag && alu_zero) |=> pc == $past(pc4) + $past(boff));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        jmp_flag |=> pc == {$past(pc4[31:28]), $past(instr[25:0]), 2'b00});

    // R8
    oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pc[31:2] >= 30'(DEPTH)) |-> instr == 32'd0);
endmodule

bind ifu_fetch_unit ifu_fetch_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .br_flag  (br_flag),
    .jmp_flag (jmp_flag),
    .alu_zero (alu_zero),
    .instr    (instr),
    .pc       (pc)
);

// File: tb/tb_ifu_fetch_unit.sv
`timescale 1ns/1ps
module tb_ifu_fetch_unit;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic          br_flag = 1'b0;
    logic          jmp_flag = 1'b0;
    logic          alu_zero = 1'b0;
    logic [31:0]   instr;
    logic [31:0]   pc;

    logic [31:0] shadow [DEPTH];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ifu_fetch_unit #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .br_flag(br_flag), .jmp_flag(jmp_flag), .alu_zero(alu_zero),
        .instr(instr), .pc(pc)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        return (a[31:2] < 30'(DEPTH)) ? shadow[a[31:2]] : 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = AW'(idx); ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
        shadow[idx] = w;
    endtask

    task automatic step(input bit b, input bit j, input bit z);
        @(negedge clk);
        br_flag = b; jmp_flag = j; alu_zero = z;
        @(posedge clk); #1;
    endtask

    task automatic expect_at(input string req, input logic [31:0] exp_pc);
        check(req, pc, exp_pc);
        check({req, "/R7"}, instr, exp_word(exp_pc));
    endtask

    task automatic t_preload_reset();
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) load(i, 32'hA500_0000 | 32'(i));
        load(3,  {6'b000100, 5'd1, 5'd2, 16'd5});       // branch +5 words
        load(11, {6'b000100, 5'd1, 5'd2, 16'hFFF8});     // branch -8 words
        load(4,  {6'b000010, 26'd20});                   // jump to word 20
        load(20, {6'b000010, 26'd100});                  // jump out of range
        step(0, 0, 0);
        check("R1", pc, 32'd0);
        check("R9", instr, shadow[0]);
    endtask

    task automatic t_sequential();
        rst = 1'b0;
        step(0, 0, 0); expect_at("R2", 32'd4);
        step(0, 0, 0); expect_at("R2", 32'd8);
        step(0, 0, 0); expect_at("R2", 32'd12);
    endtask

    task automatic t_branch_fwd();
        step(1, 0, 1); expect_at("R3", 32'd36);
    endtask

    task automatic t_branch_gate();
        step(1, 0, 0); expect_at("R4", 32'd40);
        step(0, 0, 1); expect_at("R4", 32'd44);
    endtask

    task automatic t_branch_back();
        step(1, 0, 1); expect_at("R3", 32'd16);
    endtask

    task automatic t_jump_priority();
        step(1, 1, 1); expect_at("R6", 32'd80);
    endtask

    task automatic t_out_of_range();
        step(0, 1, 0); expect_at("R5", 32'd400);
        check("R8", instr, 32'd0);
        step(0, 0, 0); expect_at("R8", 32'd404);
        check("R8", instr, 32'd0);
        step(0, 1, 0); expect_at("R8", 32'd0);
    endtask

    task automatic t_reload_running();
        load(1, 32'h1234_5678);
        rst = 1'b1;
        step(0, 0, 0); check("R1", pc, 32'd0);
        rst = 1'b0;
        step(0, 0, 0); expect_at("R9", 32'd4);
        check("R9", instr, 32'h1234_5678);
    endtask

    initial begin
        t_preload_reset();
        t_sequential();
        t_branch_fwd();
        t_branch_gate();
        t_branch_back();
        t_jump_priority();
        t_out_of_range();
        t_reload_running();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule